// File: doc/BRIEF.md
# Carry-Linked Two-Stage Logic Cell Row

This block is a row of configurable logic cells. Each cell is split into two halves. Every half owns four private data inputs and two small 3-input lookup tables. The two table outputs are the operands of a 1-bit full adder. The adder's carry-in acts as a fifth input to the half's function. Each half therefore computes a 5-input function built from a sum and a carry.

The carry enters the upper half of a cell and passes to the lower half. It then leaves the cell and enters the upper half of the next cell. Because the carry uses this dedicated path, chained functions need no general routing between them. A row of `CELLS` cells forms one ripple chain from `carry_in` to `carry_out`.

All table contents sit in a single serial configuration chain. That chain loads one bit per clock while the load enable is high. The data path is purely combinational once the chain is loaded.

Top module: `carry_logic_row`

## Requirements
- R1: An active-low reset clears every configuration bit to 0. With all tables at 0, the upper half of cell 0 outputs a sum equal to `carry_in`. Every other sum is 0, and every half carry-out and `carry_out` is 0.
- R2: While `cfg_en` is 1, each rising clock edge shifts the whole configuration chain by one position. The new bit enters at the top position. After `CELLS*32` shifts, the bit loaded first sits at position 0.
- R3: Position `32*k + 16*h + 8*t + e` holds entry `e` of table `t` (0 = operand A, 1 = operand B) of half `h` (0 = upper, 1 = lower) in cell `k`. The chain's lowest bit leaves on `cfg_out`.
- R4: While `cfg_en` is 0, the configuration holds its value whatever `cfg_in` does.
- R5: Half `h` of cell `k` uses `data_in[8*k + 4*h + j]` as its input `ij`, for `j` = 0 to 3. Table A is indexed by {i3,i2,i1}, with i3 as the most significant bit, and i0 has no effect on it.
- R6: Table B is indexed by {i3,i2,i0}, with i3 as the most significant bit, and i1 has no effect on it.
- R7: Each half's sum (`sum_out[2*k+h]`) is the odd parity of A, B and its carry-in.
- R8: Each half's carry-out (`half_cout[2*k+h]`) is 1 when at least two of A, B and its carry-in are 1.
- R9: The carry path runs in this order. `carry_in` feeds the upper half of cell 0. Each upper half feeds the lower half of the same cell. Each lower half feeds the upper half of the next cell. The lower half of the last cell drives `carry_out`.
- R10: Sums and carries follow `data_in` and `carry_in` combinationally, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Active-low reset that clears the configuration |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_in | input | 1 | Serial configuration bit, entering at the top of the chain |
| cfg_out | output | 1 | Lowest configuration bit, for cascading a further chain |
| data_in | input | CELLS*8 | Four data inputs per half, eight per cell |
| carry_in | input | 1 | Carry entering the upper half of cell 0 |
| sum_out | output | CELLS*2 | Sum of each half; index 2k is the upper half, 2k+1 the lower half |
| half_cout | output | CELLS*2 | Carry-out of each half, indexed the same way as sum_out |
| carry_out | output | 1 | Carry leaving the lower half of the last cell |

## Verification
The bench loads several configurations and sweeps all 512 combinations of one cell's eight inputs plus the incoming carry. The other cells receive bijective images of the same pattern. Every output is compared with an arithmetic model of the row.

Several corner cases get dedicated tests:
- A single-bit configuration placed at a known chain position catches a design whose shift order or field offsets are wrong, because the wrong table entry lights up.
- Toggling the unused index input of each table catches a table wired to the wrong inputs.
- A long carry propagate pattern catches a ripple that skips a half or runs the wrong way.
- Wiggling `cfg_in` while loading is disabled catches a configuration that leaks.

// File: rtl/clc_pkg.sv
package clc_pkg;

  localparam int unsigned TABLE_BITS  = 8;
  localparam int unsigned TABLE_SEL_W = $clog2(TABLE_BITS);
  localparam int unsigned HALF_INS    = 4;
  localparam int unsigned HALF_BITS   = 2 * TABLE_BITS;
  localparam int unsigned CELL_BITS   = 2 * HALF_BITS;
  localparam int unsigned CELL_INS    = 2 * HALF_INS;

  typedef struct packed {
    logic sum;
    logic carry;
  } fa_result_t;

  // Operand A table index: {i3,i2,i1}; i0 is not used.
  function automatic logic [TABLE_SEL_W-1:0] sel_operand_a(input logic [HALF_INS-1:0] ins);
    return {ins[3], ins[2], ins[1]};
  endfunction

  // Operand B table index: {i3,i2,i0}; i1 is not used.
  function automatic logic [TABLE_SEL_W-1:0] sel_operand_b(input logic [HALF_INS-1:0] ins);
    return {ins[3], ins[2], ins[0]};
  endfunction

  // One-bit full adder: generate when both operands are 1, propagate when they differ.
  function automatic fa_result_t full_add(input logic a, input logic b, input logic cin);
    fa_result_t r;
    logic       prop;
    prop    = a ^ b;
    r.sum   = prop ^ cin;
    r.carry = (a & b) | (prop & cin);
    return r;
  endfunction

endpackage

// File: rtl/lut3_table.sv
module lut3_table
  import clc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   shift_en,
  input  logic                   shift_in,
  output logic                   shift_out,
  input  logic [TABLE_SEL_W-1:0] sel,
  output logic                   bit_out
);

  logic [TABLE_BITS-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (shift_en) begin
      store_q <= {shift_in, store_q[TABLE_BITS-1:1]};
    end
  end

  assign shift_out = store_q[0];
  assign bit_out   = store_q[sel];

  // R2: one step of the chain per enabled edge, new bit at the top
  a_r2_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (store_q[TABLE_BITS-2:0] == $past(store_q[TABLE_BITS-1:1]))
                 && (store_q[TABLE_BITS-1] == $past(shift_in)));

  // R4: disabled chain keeps its contents
  a_r4_hold_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(store_q));

endmodule

// File: rtl/carry_half.sv
module carry_half
  import clc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                shift_in,
  output logic                shift_out,
  input  logic [HALF_INS-1:0] din,
  input  logic                cin,
  output logic                sum,
  output logic                cout
);

  logic [TABLE_SEL_W-1:0] sel_a;
  logic [TABLE_SEL_W-1:0] sel_b;
  logic                   op_a;
  logic                   op_b;
  logic                   link_ba;
  fa_result_t             add_res;

  assign sel_a = sel_operand_a(din);
  assign sel_b = sel_operand_b(din);

  // Table B occupies the higher chain offset, so it receives the chain first.
  lut3_table u_tab_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .shift_in  (shift_in),
    .shift_out (link_ba),
    .sel       (sel_b),
    .bit_out   (op_b)
  );

  lut3_table u_tab_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .shift_in  (link_ba),
    .shift_out (shift_out),
    .sel       (sel_a),
    .bit_out   (op_a)
  );

  assign add_res = full_add(op_a, op_b, cin);
  assign sum     = add_res.sum;
  assign cout    = add_res.carry;

  // R8: equal operands decide the carry by themselves
  a_r8_carry_generate: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a == op_b) |-> (cout == op_a));

  // R8: differing operands pass the incoming carry through
  a_r8_carry_propagate: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a != op_b) |-> (cout == cin));

  // R7: operands, carry-in and sum together hold an even number of ones
  a_r7_sum_parity: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({op_a, op_b, cin, sum}) % 2) == 0);

endmodule

// File: rtl/carry_cell.sv
module carry_cell
  import clc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                shift_in,
  output logic                shift_out,
  input  logic [CELL_INS-1:0] din,
  input  logic                cin,
  output logic [1:0]          sum,
  output logic [1:0]          half_co
);

  logic mid_carry;
  logic link_lu;

  // Lower half holds the higher chain offset and receives the chain first.
  carry_half u_lower (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .shift_in  (shift_in),
    .shift_out (link_lu),
    .din       (din[CELL_INS-1:HALF_INS]),
    .cin       (mid_carry),
    .sum       (sum[1]),
    .cout      (half_co[1])
  );

  carry_half u_upper (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .shift_in  (link_lu),
    .shift_out (shift_out),
    .din       (din[HALF_INS-1:0]),
    .cin       (cin),
    .sum       (sum[0]),
    .cout      (mid_carry)
  );

  assign half_co[0] = mid_carry;

endmodule

// File: rtl/carry_logic_row.sv
module carry_logic_row
  import clc_pkg::*;
#(
  parameter int unsigned CELLS = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_en,
  input  logic                      cfg_in,
  output logic                      cfg_out,
  input  logic [CELLS*CELL_INS-1:0] data_in,
  input  logic                      carry_in,
  output logic [2*CELLS-1:0]        sum_out,
  output logic [2*CELLS-1:0]        half_cout,
  output logic                      carry_out
);

  localparam int unsigned DATA_W = CELLS * CELL_INS;

  logic [CELLS:0] cfg_link;
  logic [CELLS:0] carry_link;

  assign cfg_link[CELLS] = cfg_in;
  assign carry_link[0]   = carry_in;

  for (genvar k = 0; k < CELLS; k++) begin : g_cell
    carry_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (cfg_en),
      .shift_in  (cfg_link[k+1]),
      .shift_out (cfg_link[k]),
      .din       (data_in[k*CELL_INS +: CELL_INS]),
      .cin       (carry_link[k]),
      .sum       (sum_out[2*k +: 2]),
      .half_co   (half_cout[2*k +: 2])
    );
    assign carry_link[k+1] = half_cout[2*k+1];
  end

  assign cfg_out   = cfg_link[0];
  assign carry_out = carry_link[CELLS];

  // R9: carry leaving the row matches the last lower half
  a_r9_row_end: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out == half_cout[2*CELLS-1]);

  if (DATA_W < 1) begin : g_bad_width
    initial $error("carry_logic_row: CELLS must be at least 1");
  end

endmodule

// File: tb/carry_logic_row_test.sv
module carry_logic_row_test;

  localparam int CELLS = 3;
  localparam int TOTAL = CELLS * 32;
  localparam int DW    = CELLS * 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_en = 1'b0;
  logic             cfg_in = 1'b0;
  logic             cfg_out;
  logic [DW-1:0]    data_in = '0;
  logic             carry_in = 1'b0;
  logic [2*CELLS-1:0] sum_out;
  logic [2*CELLS-1:0] half_cout;
  logic             carry_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  carry_logic_row #(.CELLS(CELLS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .data_in(data_in), .carry_in(carry_in), .sum_out(sum_out),
    .half_cout(half_cout), .carry_out(carry_out)
  );

  function automatic logic [31:0] next_rand(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // Arithmetic model: each half adds its two looked-up bits and the incoming carry.
  task automatic model(input logic [TOTAL-1:0] cfg, input logic [DW-1:0] d, input logic ci,
                       output logic [2*CELLS-1:0] s, output logic [2*CELLS-1:0] co,
                       output logic cend);
    logic c;
    c = ci;
    for (int k = 0; k < CELLS; k++) begin
      for (int h = 0; h < 2; h++) begin
        logic [3:0] nib;
        logic [7:0] ta, tb;
        logic [1:0] tot;
        int         ia, ib;
        nib = d[8*k + 4*h +: 4];
        ta  = cfg[32*k + 16*h +: 8];
        tb  = cfg[32*k + 16*h + 8 +: 8];
        ia  = 4*nib[3] + 2*nib[2] + nib[1];
        ib  = 4*nib[3] + 2*nib[2] + nib[0];
        tot = {1'b0, ta[ia]} + {1'b0, tb[ib]} + {1'b0, c};
        s[2*k+h]  = tot[0];
        co[2*k+h] = tot[1];
        c = tot[1];
      end
    end
    cend = c;
  endtask

  task automatic check_vec(input string tag, input logic [TOTAL-1:0] cfg,
                           input logic [DW-1:0] d, input logic ci);
    logic [2*CELLS-1:0] es, eco;
    logic               ec;
    data_in  = d;
    carry_in = ci;
    #1;
    model(cfg, d, ci, es, eco, ec);
    checks++;
    if (sum_out !== es || half_cout !== eco || carry_out !== ec) begin
      fails++;
      $display("FAIL %s data=%h cin=%b: got sum=%b co=%b end=%b, expected sum=%b co=%b end=%b",
               tag, d, ci, sum_out, half_cout, carry_out, es, eco, ec);
    end
  endtask

  // R2: bits go in lowest first so that bit i ends at chain position i.
  task automatic load_cfg(input logic [TOTAL-1:0] v);
    for (int i = 0; i < TOTAL; i++) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = v[i];
    end
    @(negedge clk);
    cfg_en = 1'b0;
    cfg_in = 1'b0;
  endtask

  function automatic logic [TOTAL-1:0] rand_cfg();
    logic [TOTAL-1:0] v;
    for (int w = 0; w < TOTAL / 32; w++) begin
      lcg = next_rand(lcg);
      v[32*w +: 32] = lcg;
    end
    return v;
  endfunction

  task automatic sweep(input string tag, input logic [TOTAL-1:0] cfg);
    for (int v = 0; v < 512; v++) begin
      logic [DW-1:0] d;
      for (int k = 0; k < CELLS; k++) d[8*k +: 8] = v[7:0] ^ (8'h5A * k[7:0]);
      check_vec(tag, cfg, d, v[8]);
    end
  endtask

  initial begin : watchdog
    #(200000 * 10);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [TOTAL-1:0] cfg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: cleared tables; sum of cell 0 upper follows carry_in
    check_vec("R1 reset cin=1", '0, 24'hFFFFFF, 1'b1);
    check_vec("R1 reset cin=0", '0, 24'hA5C33C, 1'b0);

    // R2 R3: single 1 at cell 1, upper half, table B, entry 5 (i3=1,i2=0,i0=1)
    cfg = '0;
    cfg[32*1 + 16*0 + 8*1 + 5] = 1'b1;
    load_cfg(cfg);
    check_vec("R2 R3 placed bit hit", cfg, 24'h000900, 1'b0);
    check_vec("R2 R3 placed bit miss", cfg, 24'h000800, 1'b0);
    checks++;
    if (cfg_out !== 1'b0) begin
      fails++;
      $display("FAIL R3 cfg_out got %b expected 0", cfg_out);
    end

    // R5: cell 0 upper table A holds 1 only at index 1 (i1=1), table B zero
    cfg = '0;
    cfg[1] = 1'b1;
    load_cfg(cfg);
    check_vec("R5 A index hit", cfg, 24'h000002, 1'b0);
    check_vec("R5 A ignores i0", cfg, 24'h000003, 1'b0);
    check_vec("R5 A miss on i0 only", cfg, 24'h000001, 1'b0);

    // R6: cell 0 lower table B holds 1 only at index 1 (i0=1)
    cfg = '0;
    cfg[16 + 8 + 1] = 1'b1;
    load_cfg(cfg);
    check_vec("R6 B index hit", cfg, 24'h000010, 1'b0);
    check_vec("R6 B ignores i1", cfg, 24'h000030, 1'b0);
    check_vec("R6 B miss on i1 only", cfg, 24'h000020, 1'b0);

    // R9: every half propagates (A all ones, B all zeros); carry runs the whole row
    cfg = '0;
    for (int p = 0; p < 2 * CELLS; p++) cfg[16*p +: 8] = 8'hFF;
    load_cfg(cfg);
    check_vec("R9 ripple full length cin=1", cfg, 24'h000000, 1'b1);
    check_vec("R9 ripple full length cin=0", cfg, 24'h000000, 1'b0);

    // R4: wiggle cfg_in with loading disabled, then the function must be unchanged
    cfg = rand_cfg();
    load_cfg(cfg);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      cfg_in = i[0];
    end
    cfg_in = 1'b0;
    check_vec("R4 hold after cfg_in activity", cfg, 24'h3C96E1, 1'b1);

    // R7 R8 R9 R10: exhaustive per-cell sweeps under several configurations
    sweep("R7 R8 R9 R10 random cfg A", cfg);
    for (int n = 0; n < 3; n++) begin
      cfg = rand_cfg();
      load_cfg(cfg);
      sweep("R7 R8 R9 R10 random cfg", cfg);
    end

    // R1: reset clears a loaded configuration
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R1 reset after load", '0, 24'h5A5A5A, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule